// File: doc/BRIEF.md
# Dual-Line Prioritised Interrupt Controller

This block collects 64 level-sensitive interrupt sources and presents them to a processor on two request lines: a normal line and a fast line. Every source carries an enable bit, a bit that steers it to the fast line, and a 4-bit priority. The normal line is further gated by a 5-bit threshold, so software can hold back low-priority work without touching the individual enables.

Software reaches the block through a simple 32-bit word-addressed read/write port. Reading one of the two acknowledge registers returns the winning source for that line and, in the same cycle, retires that source's pending bit. For the normal line the winner is the source with the highest priority. For the fast line it is the source with the lowest number. Enables can be changed as whole 32-bit halves, or one at a time by writing a source number. All offsets below are byte offsets. The port `addr_i` carries offset bits [11:2].

Top module: `dual_line_intc`

## Requirements
- R1: A rising edge on `src_i[n]` sets pending bit n and a falling edge clears it. The pending vector reads back at 0x48 (sources 63..32) and 0x4C (sources 31..0), with bit n of each word belonging to source 32+n or n.
- R2: `fiq_o` is high exactly when some source is pending, enabled and has its fast-route bit set.
- R3: `irq_o` is high when some pending, enabled, non-fast source has a priority strictly greater than the threshold at 0x04. A threshold of 0x1F lets any such source through, and thresholds 0x10 to 0x1E block all of them. The threshold keeps data bits [4:0].
- R4: After reset the threshold reads 0x1F. Enable, fast-route, pending, control and all priorities read zero, and both request lines are low.
- R5: A write to 0x08 sets the enable bit numbered by data bits [5:0]. A write to 0x0C clears that bit. Higher data bits are ignored.
- R6: Enables are written and read as halves at 0x10 (63..32) and 0x14 (31..0), and fast-route bits at 0x18 and 0x1C. Pending is overwritten by writes to 0x50 (upper) and 0x54 (lower); both of these offsets read zero.
- R7: 0x58/0x5C read the pending-and-enabled normal sources, and 0x60/0x64 read the pending-and-enabled fast sources, upper half first.
- R8: The priorities occupy 0x20..0x3C. Offset 0x3C holds sources 0..7, and each lower word holds the next eight sources, down to 0x20, which holds 56..63. Source s sits in nibble s mod 8 (bits 4*(s mod 8)+3 : 4*(s mod 8)).
- R9: A read of 0x40 returns (index << 16) | priority of the highest-priority pending, enabled, normal source and clears its pending bit. Among equal priorities the higher index wins. With no candidate the read returns 0xFFFFFFFF.
- R10: A read of 0x44 returns the index of the lowest-numbered pending, enabled, fast source and clears its pending bit, or returns 0xFFFFFFFF if there is none.
- R11: The control word at 0x00 keeps only bits 24 and 22..18 of the written data (mask 0x017C0000). Bit 25, the write-one-to-clear abort flag, has no setter and reads zero.
- R12: Writes anywhere in 0x100..0x2FC change no state. A read of 0x100 returns 4, and reads of unlisted offsets return zero.
- R13: `irq_o` and `fiq_o` take their new value at the clock edge that accepts the write, the acknowledge or the input edge. `rdata_o` is loaded at the edge that samples `rd_en_i` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level interrupt sources |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; an acknowledge side effect happens on this edge |
| addr_i | input | 10 | Word address (byte offset bits [11:2]) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted pending, enable or fast-route bit shows up at the request lines at the very next clock edge, because both lines are registered from the next state. It also shows up in the read data on the following read of the pending or active-view words. A wrong priority or a wrong tie-break shows up only as a wrong acknowledge order or a wrong threshold decision, so the bench drains a set of sources with mixed and equal priorities and compares every returned word. An acknowledge that fails to retire its source repeats the same word on the next read, which is caught one read later.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_SRC = 64;
  localparam int PRIO_W  = 4;
  localparam int THR_W   = 5;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 10;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int HALF    = NUM_SRC / 2;
  localparam int PER_WRD = DATA_W / PRIO_W;

  // word addresses (byte offset >> 2)
  localparam logic [ADDR_W-1:0] A_CTL     = 10'h000;
  localparam logic [ADDR_W-1:0] A_THR     = 10'h001;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 10'h002;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 10'h003;
  localparam logic [ADDR_W-1:0] A_EN_HI   = 10'h004;
  localparam logic [ADDR_W-1:0] A_EN_LO   = 10'h005;
  localparam logic [ADDR_W-1:0] A_FST_HI  = 10'h006;
  localparam logic [ADDR_W-1:0] A_FST_LO  = 10'h007;
  localparam logic [ADDR_W-1:0] A_PRI_LO  = 10'h008;
  localparam logic [ADDR_W-1:0] A_PRI_HI  = 10'h00F;
  localparam logic [ADDR_W-1:0] A_ACK_NRM = 10'h010;
  localparam logic [ADDR_W-1:0] A_ACK_FST = 10'h011;
  localparam logic [ADDR_W-1:0] A_PND_HI  = 10'h012;
  localparam logic [ADDR_W-1:0] A_PND_LO  = 10'h013;
  localparam logic [ADDR_W-1:0] A_FRC_HI  = 10'h014;
  localparam logic [ADDR_W-1:0] A_FRC_LO  = 10'h015;
  localparam logic [ADDR_W-1:0] A_NRM_HI  = 10'h016;
  localparam logic [ADDR_W-1:0] A_NRM_LO  = 10'h017;
  localparam logic [ADDR_W-1:0] A_FSA_HI  = 10'h018;
  localparam logic [ADDR_W-1:0] A_FSA_LO  = 10'h019;
  localparam logic [ADDR_W-1:0] A_VEC_LO  = 10'h040;
  localparam logic [ADDR_W-1:0] A_VEC_HI  = 10'h0BF;

  localparam logic [DATA_W-1:0] CTL_MASK  = 32'h017C_0000;
  localparam logic [DATA_W-1:0] ID_WORD   = 32'h0000_0004;
  localparam logic [DATA_W-1:0] NONE_WORD = 32'hFFFF_FFFF;
  localparam logic [THR_W-1:0]  THR_OPEN  = 5'h1F;

  typedef logic [NUM_SRC-1:0]              src_vec_t;
  typedef logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_arr_t;

  typedef struct packed {
    logic              vld;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] prio;
  } pick_t;
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick
  import vic_pkg::*;
(
  input  src_vec_t  act_i,
  input  prio_arr_t prio_i,
  output pick_t     win_o
);
  // ascending scan with >= : on equal priority the higher index wins
  always_comb begin
    win_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act_i[i] && (!win_o.vld || prio_i[i] >= win_o.prio)) begin
        win_o.vld  = 1'b1;
        win_o.idx  = IDX_W'(i);
        win_o.prio = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/vic_low_pick.sv
module vic_low_pick
  import vic_pkg::*;
(
  input  src_vec_t         act_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_thr_gate.sv
module vic_thr_gate
  import vic_pkg::*;
(
  input  src_vec_t         act_i,
  input  prio_arr_t        prio_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             hit_o
);
  src_vec_t above;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign above[g] = act_i[g] && (THR_W'(prio_i[g]) > thr_i);
  end

  assign hit_o = (thr_i == THR_OPEN) ? (|act_i) : (|above);
endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
  import vic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [9:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  src_vec_t          pend_q, en_q, fast_q, src_q;
  src_vec_t          pend_d, en_d, fast_d;
  prio_arr_t         prio_q, prio_d;
  logic [THR_W-1:0]  thr_q, thr_d;
  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic [DATA_W-1:0] rd_val;
  logic              irq_d, fiq_d;

  src_vec_t          act_nrm, act_fst, nxt_nrm;
  pick_t             nrm_win;
  logic              fst_vld;
  logic [IDX_W-1:0]  fst_idx;

  logic              ack_nrm, ack_fst, in_vec;
  logic [IDX_W-1:0]  en_sel;
  logic [IDX_W-1:0]  pri_base;

  assign act_nrm = pend_q & en_q & ~fast_q;
  assign act_fst = pend_q & en_q & fast_q;

  vic_prio_pick u_nrm_pick (
    .act_i  (act_nrm),
    .prio_i (prio_q),
    .win_o  (nrm_win)
  );

  vic_low_pick u_fst_pick (
    .act_i (act_fst),
    .vld_o (fst_vld),
    .idx_o (fst_idx)
  );

  assign ack_nrm  = rd_en_i && (addr_i == A_ACK_NRM) && nrm_win.vld;
  assign ack_fst  = rd_en_i && (addr_i == A_ACK_FST) && fst_vld;
  assign in_vec   = (addr_i >= A_VEC_LO) && (addr_i <= A_VEC_HI);
  assign en_sel   = wdata_i[IDX_W-1:0];
  // priority word 0x3C holds sources 0..7, 0x20 holds 56..63
  assign pri_base = {~addr_i[2:0], 3'b000};

  // next state: source edges, then acknowledge, then software writes
  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    fast_d = fast_q;
    prio_d = prio_q;
    thr_d  = thr_q;
    ctl_d  = ctl_q;

    pend_d = (pend_d | (src_i & ~src_q)) & ~(~src_i & src_q);
    if (ack_nrm) pend_d[nrm_win.idx] = 1'b0;
    if (ack_fst) pend_d[fst_idx]     = 1'b0;

    if (wr_en_i && !in_vec) begin
      unique case (addr_i)
        A_CTL:    ctl_d = wdata_i & CTL_MASK;
        A_THR:    thr_d = wdata_i[THR_W-1:0];
        A_EN_SET: en_d[en_sel] = 1'b1;
        A_EN_CLR: en_d[en_sel] = 1'b0;
        A_EN_HI:  en_d[NUM_SRC-1:HALF]   = wdata_i;
        A_EN_LO:  en_d[HALF-1:0]         = wdata_i;
        A_FST_HI: fast_d[NUM_SRC-1:HALF] = wdata_i;
        A_FST_LO: fast_d[HALF-1:0]       = wdata_i;
        A_FRC_HI: pend_d[NUM_SRC-1:HALF] = wdata_i;
        A_FRC_LO: pend_d[HALF-1:0]       = wdata_i;
        default: begin
          if (addr_i >= A_PRI_LO && addr_i <= A_PRI_HI)
            prio_d[pri_base +: PER_WRD] = wdata_i;
        end
      endcase
    end
  end

  assign nxt_nrm = pend_d & en_d & ~fast_d;
  assign fiq_d   = |(pend_d & en_d & fast_d);

  vic_thr_gate u_gate (
    .act_i  (nxt_nrm),
    .prio_i (prio_d),
    .thr_i  (thr_d),
    .hit_o  (irq_d)
  );

  // read mux from current state
  always_comb begin
    rd_val = '0;
    unique case (addr_i)
      A_CTL:     rd_val = ctl_q;
      A_THR:     rd_val = DATA_W'(thr_q);
      A_EN_HI:   rd_val = en_q[NUM_SRC-1:HALF];
      A_EN_LO:   rd_val = en_q[HALF-1:0];
      A_FST_HI:  rd_val = fast_q[NUM_SRC-1:HALF];
      A_FST_LO:  rd_val = fast_q[HALF-1:0];
      A_ACK_NRM: rd_val = nrm_win.vld
                          ? {10'b0, nrm_win.idx, 12'b0, nrm_win.prio}
                          : NONE_WORD;
      A_ACK_FST: rd_val = fst_vld ? DATA_W'(fst_idx) : NONE_WORD;
      A_PND_HI:  rd_val = pend_q[NUM_SRC-1:HALF];
      A_PND_LO:  rd_val = pend_q[HALF-1:0];
      A_NRM_HI:  rd_val = act_nrm[NUM_SRC-1:HALF];
      A_NRM_LO:  rd_val = act_nrm[HALF-1:0];
      A_FSA_HI:  rd_val = act_fst[NUM_SRC-1:HALF];
      A_FSA_LO:  rd_val = act_fst[HALF-1:0];
      A_VEC_LO:  rd_val = ID_WORD;
      default: begin
        if (addr_i >= A_PRI_LO && addr_i <= A_PRI_HI)
          rd_val = prio_q[pri_base +: PER_WRD];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      en_q    <= '0;
      fast_q  <= '0;
      src_q   <= '0;
      prio_q  <= '0;
      thr_q   <= THR_OPEN;
      ctl_q   <= '0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      fast_q <= fast_d;
      src_q  <= src_i;
      prio_q <= prio_d;
      thr_q  <= thr_d;
      ctl_q  <= ctl_d;
      irq_o  <= irq_d;
      fiq_o  <= fiq_d;
      if (rd_en_i) rdata_o <= rd_val;
    end
  end
endmodule

// File: rtl/dual_line_intc_chk.sv
module dual_line_intc_chk
  import vic_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [9:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        irq_o,
  input logic        fiq_o,
  input src_vec_t    pend_q,
  input src_vec_t    en_q,
  input src_vec_t    fast_q
);
  logic any_nrm;
  assign any_nrm = |(pend_q & en_q & ~fast_q);

  assert_fiq_tracks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == |(pend_q & en_q & fast_q));

  assert_irq_needs_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_nrm |-> !irq_o);

  assert_en_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_EN_SET) |=> en_q[$past(wdata_i[IDX_W-1:0])]);

  assert_ack_none_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_ACK_NRM && !any_nrm) |=> rdata_o == NONE_WORD);

  assert_ack_retires_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_ACK_NRM && any_nrm) |=> !pend_q[rdata_o[21:16]]);

  assert_fst_none_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_ACK_FST && !(|(pend_q & en_q & fast_q)))
      |=> rdata_o == NONE_WORD);

  assert_vec_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i >= A_VEC_LO && addr_i <= A_VEC_HI)
      |=> ($stable(en_q) && $stable(fast_q)));
endmodule

bind dual_line_intc dual_line_intc_chk u_chk (.*);

// File: tb/dual_line_intc_tb.sv
module dual_line_intc_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dual_line_intc u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk); addr = off[11:2]; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] off, output logic [31:0] d);
    @(negedge clk); addr = off[11:2]; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] off, input logic [31:0] exp);
    logic [31:0] d;
    rd(off, d);
    chk(req, d, exp);
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R4 irq", {31'b0, irq}, 0);
    chk("R4 fiq", {31'b0, fiq}, 0);
    rd_chk("R4 thr", 12'h004, 32'h1F);
    rd_chk("R4 en", 12'h014, 0);
    rd_chk("R4 pend", 12'h048, 0);
    rd_chk("R4 ctl", 12'h000, 0);
    rd_chk("R4 prio", 12'h03C, 0);
  endtask

  task automatic t_pending;
    set_src(64'h0000_0100_0000_0008);
    rd_chk("R1 pend lo", 12'h04C, 32'h8);
    rd_chk("R1 pend hi", 12'h048, 32'h100);
    chk("R2 no fiq when disabled", {31'b0, fiq}, 0);
    set_src(64'h0000_0100_0000_0000);
    rd_chk("R1 fall clears", 12'h04C, 32'h0);
    set_src('0);
    rd_chk("R1 hi clears", 12'h048, 32'h0);
  endtask

  task automatic t_enable;
    wr(12'h008, 32'd5);
    wr(12'h008, 32'h47);
    rd_chk("R5 set by number", 12'h014, 32'hA0);
    wr(12'h00C, 32'd5);
    rd_chk("R5 clear by number", 12'h014, 32'h80);
    wr(12'h008, 32'd63);
    rd_chk("R5 set 63", 12'h010, 32'h8000_0000);
    wr(12'h010, 0); wr(12'h014, 0);
  endtask

  task automatic t_halves;
    wr(12'h018, 32'h0000_1234);
    wr(12'h01C, 32'hCAFE_0000);
    rd_chk("R6 fast hi", 12'h018, 32'h0000_1234);
    rd_chk("R6 fast lo", 12'h01C, 32'hCAFE_0000);
    wr(12'h054, 32'h0000_F00F);
    rd_chk("R6 force lo", 12'h04C, 32'h0000_F00F);
    rd_chk("R6 force reads zero", 12'h054, 0);
    wr(12'h018, 0); wr(12'h01C, 0); wr(12'h054, 0);
  endtask

  task automatic t_prio_layout;
    wr(12'h03C, 32'h7654_3210);
    wr(12'h020, 32'hFF00_0000);
    rd_chk("R8 word 0x3C", 12'h03C, 32'h7654_3210);
    rd_chk("R8 word 0x20", 12'h020, 32'hFF00_0000);
    rd_chk("R8 untouched word", 12'h038, 0);
  endtask

  task automatic t_fast;
    wr(12'h008, 32'd2);
    wr(12'h01C, 32'h4);
    set_src(64'h4);
    chk("R2 fiq high", {31'b0, fiq}, 1);
    chk("R13 irq low for fast src", {31'b0, irq}, 0);
    rd_chk("R7 fast view", 12'h064, 32'h4);
    rd_chk("R7 normal view empty", 12'h05C, 0);
    rd_chk("R10 ack fast", 12'h044, 32'd2);
    chk("R13 fiq drops on ack edge", {31'b0, fiq}, 0);
    rd_chk("R10 ack empty", 12'h044, 32'hFFFF_FFFF);
    wr(12'h014, 32'h24); wr(12'h01C, 32'h24); wr(12'h054, 32'h24);
    rd_chk("R10 lowest first", 12'h044, 32'd2);
    rd_chk("R10 next", 12'h044, 32'd5);
    rd_chk("R10 drained", 12'h044, 32'hFFFF_FFFF);
    set_src('0);
    wr(12'h01C, 0); wr(12'h014, 0);
  endtask

  task automatic t_threshold;
    wr(12'h014, 32'h20);
    wr(12'h054, 32'h20);
    chk("R3 open threshold", {31'b0, irq}, 1);
    wr(12'h004, 32'd4);
    chk("R3 prio 5 > 4", {31'b0, irq}, 1);
    wr(12'h004, 32'd5);
    chk("R3 strict compare", {31'b0, irq}, 0);
    wr(12'h004, 32'd16);
    chk("R3 threshold 16 blocks", {31'b0, irq}, 0);
    wr(12'h004, 32'd0);
    chk("R3 threshold 0", {31'b0, irq}, 1);
    wr(12'h004, 32'hFF);
    rd_chk("R3 thr keeps 5 bits", 12'h004, 32'h1F);
    wr(12'h054, 0); wr(12'h014, 0);
    chk("R3 no source", {31'b0, irq}, 0);
  endtask

  task automatic t_ack_normal;
    wr(12'h014, 32'h4A); wr(12'h010, 32'hC000_0000);
    wr(12'h054, 32'h4A); wr(12'h050, 32'hC000_0000);
    rd_chk("R7 normal lo", 12'h05C, 32'h4A);
    rd_chk("R7 normal hi", 12'h058, 32'hC000_0000);
    rd_chk("R7 fast hi empty", 12'h060, 0);
    chk("R3 irq pending", {31'b0, irq}, 1);
    rd_chk("R9 tie higher index", 12'h040, 32'h003F_000F);
    rd_chk("R13 rdata holds", 12'h0F0, 32'h0);
    chk("R13 rdata held idle", rdata, 32'h0);
    rd_chk("R9 second", 12'h040, 32'h003E_000F);
    rd_chk("R9 prio 6", 12'h040, 32'h0006_0006);
    rd_chk("R9 prio 3", 12'h040, 32'h0003_0003);
    chk("R3 irq still high", {31'b0, irq}, 1);
    rd_chk("R9 prio 1", 12'h040, 32'h0001_0001);
    chk("R3 irq low when drained", {31'b0, irq}, 0);
    rd_chk("R9 empty", 12'h040, 32'hFFFF_FFFF);
    rd_chk("R1 pending cleared by ack", 12'h04C, 0);
    wr(12'h014, 0); wr(12'h010, 0);
  endtask

  task automatic t_ctl;
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R11 masked ctl", 12'h000, 32'h017C_0000);
    wr(12'h000, 32'h0200_0000);
    rd_chk("R11 flag reads zero", 12'h000, 0);
  endtask

  task automatic t_ignore;
    wr(12'h014, 32'h1);
    wr(12'h004, 32'h3);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h2FC, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    rd_chk("R12 en untouched", 12'h014, 32'h1);
    rd_chk("R12 thr untouched", 12'h004, 32'h3);
    rd_chk("R12 pend untouched", 12'h04C, 0);
    rd_chk("R12 id word", 12'h100, 32'h4);
    rd_chk("R12 unlisted", 12'h068, 0);
    rd_chk("R12 unlisted vec", 12'h104, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_enable();
    t_halves();
    t_prio_layout();
    t_fast();
    t_threshold();
    t_ack_normal();
    t_ctl();
    t_ignore();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule